// File: doc/BRIEF.md
# Phase Mismatch Jump Controller

This block sits beside a bus-transfer sequencer. While a block-move instruction runs, it compares the phase the instruction expects with the phase on the bus. When the two differ, the block does one of two things, depending on its control register. It can raise an interrupt and wait for the sequencer to acknowledge it. It can also handle the mismatch itself: it settles the FIFO, records the remaining byte count and the next address in residual registers that a later store can write back, and then issues a jump to one of two programmed alternate addresses.

Phases use a 3-bit code {MSG, C/D, I/O}: data out 000, data in 001, command 010, status 011, message out 110, message in 111. Bit 0 (I/O) is 1 for inbound transfers.

All inputs that describe the transfer are captured in the cycle the mismatch is sampled. These are the instruction phase, the wide-residue flag, the FIFO occupancy, the programmed count, the start address, the bytes moved on the memory side, and the two control bits.

The FSM has six states:
- IDLE watches for a mismatch.
- SETTLE holds a request to the FIFO: discard on a send, drain to memory on a receive. It leaves when the FIFO reports done.
- COMPUTE registers the residual count and residual address.
- JUMP drives the one-cycle strobe together with the selected target.
- WAITACK holds until the sequencer acknowledges the jump.
- IRQ holds the interrupt until it is acknowledged.

The transitions are:
- IDLE goes to IRQ when the mismatch is sampled with jumps disabled.
- IDLE goes to SETTLE with jumps enabled and a non-empty FIFO.
- IDLE goes to COMPUTE with jumps enabled and an empty FIFO.
- SETTLE goes to COMPUTE on settle-done.
- COMPUTE goes to JUMP unconditionally.
- JUMP goes to WAITACK unconditionally.
- WAITACK and IRQ go back to IDLE on acknowledge.

Top module: `pmj_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and irq, jump_stb and settle_req are 0.
- R2: Control bits 7, 6, 5, 4 and 1 are writable. Bits 3, 2 and 0 always read 0, so writing 0xFF reads back 0xF2.
- R3: With bit 7 (enable) at 0, a sampled mismatch raises irq in the next cycle. irq stays high until seq_ack, and no settle request or jump strobe is produced.
- R4: With bit 7 at 1, a sampled mismatch never raises irq. It ends in jump_stb high for exactly one cycle.
- R5: On an outbound instruction phase (bit 0 = 0) with FIFO bytes present, settle_req is raised with settle_drain = 0. The bytes transferred are moved − FIFO count. The residual count is programmed count − transferred, and the residual address is start + transferred.
- R6: On an inbound instruction phase (bit 0 = 1) with FIFO bytes present, settle_req is raised with settle_drain = 1. The bytes transferred are moved + FIFO count, and the residual count and address follow the same rule as in R5.
- R7: With an empty FIFO, no settle request is raised, and jump_stb appears in the second cycle after the mismatch is sampled.
- R8: With bit 6 (selector) at 0, the target is alternate address 1 when the wide-residue flag is clear and alternate address 2 when it is set.
- R9: With bit 6 at 1, the target is alternate address 1 for outbound instruction phases and alternate address 2 for inbound ones. The instruction phase decides, never the bus phase.
- R10: wres_flag is set when a jump-mode mismatch sees the wide-residue flag set. It is rewritten at each accepted mismatch, so it clears on a later mismatch without the flag.
- R11: A phase difference is ignored while bm_active is 0. It is also ignored from acceptance until seq_ack.
- R12: jump_stb rises in the second cycle after settle_done is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| alt_we | input | 2 | Write enables for alternate addresses 1 and 2 |
| alt_wdata | input | AW | Alternate address write data |
| bm_active | input | 1 | Block move in progress |
| bm_phase | input | 3 | Phase encoded in the instruction |
| bus_phase | input | 3 | Phase seen on the bus |
| wide_res | input | 1 | Wide-residue holding byte present |
| fifo_count | input | FW | FIFO occupancy in bytes |
| bm_count | input | CW | Programmed byte count |
| bm_start | input | AW | Transfer start address |
| bm_moved | input | CW | Bytes moved on the memory side |
| settle_req | output | 1 | FIFO settle request |
| settle_drain | output | 1 | 1 = drain to memory, 0 = discard |
| settle_done | input | 1 | FIFO settle complete |
| seq_ack | input | 1 | Sequencer acknowledges irq or jump |
| irq | output | 1 | Mismatch interrupt |
| jump_stb | output | 1 | One-cycle jump strobe |
| jump_addr | output | AW | Jump target, valid with jump_stb |
| resid_count | output | CW | Residual byte count |
| resid_addr | output | AW | Residual address |
| wres_flag | output | 1 | Wide-residue byte left for manual flush |

## Verification
The main function is tried with a range of mismatch patterns:
- A disabled-jump mismatch shows that interrupt and jump are mutually exclusive.
- A send with a partly full FIFO and a receive with a partly full FIFO separate the subtract and add paths of the residual arithmetic, and the discard and drain request.
- An empty-FIFO case checks that the settle step is skipped.
- Selector-0 cases with the wide-residue flag clear and then set tell alternate address 1 from alternate address 2.
- Selector-1 cases pair a bus phase whose direction differs from the instruction phase, so a design that chose by bus phase would pick the wrong target.

Mismatches presented with bm_active low, and again while a jump awaits acknowledge, must produce no event at all.

// File: rtl/pmj_pkg.sv
package pmj_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_COMPUTE,
        ST_JUMP,
        ST_WAITACK,
        ST_IRQ
    } pmj_state_e;

    localparam int unsigned CTL_EN_BIT  = 7;
    localparam int unsigned CTL_SEL_BIT = 6;
    localparam logic [7:0]  CTL_WMASK   = 8'hF2;
    localparam int unsigned PH_IO_BIT   = 0;

endpackage

// File: rtl/pmj_cfg.sv
module pmj_cfg
    import pmj_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned NALT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic [NALT-1:0]      alt_we,
    input  logic [AW-1:0]        alt_wdata,
    output logic                 ctl_en,
    output logic                 ctl_sel,
    output logic [NALT-1:0][AW-1:0] alt_addr
);

    logic [7:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (cfg_we) begin
            ctl_q <= cfg_wdata & CTL_WMASK;
        end
    end

    for (genvar g = 0; g < NALT; g++) begin : g_alt
        logic [AW-1:0] alt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alt_q <= '0;
            end else if (alt_we[g]) begin
                alt_q <= alt_wdata;
            end
        end
        assign alt_addr[g] = alt_q;
    end

    assign cfg_rdata = ctl_q;
    assign ctl_en    = ctl_q[CTL_EN_BIT];
    assign ctl_sel   = ctl_q[CTL_SEL_BIT];

endmodule

// File: rtl/pmj_target.sv
module pmj_target
    import pmj_pkg::*;
(
    input  logic       ctl_sel,
    input  logic [2:0] instr_phase,
    input  logic       wide_res,
    output logic       use_alt2
);

    always_comb begin
        if (ctl_sel) begin
            use_alt2 = instr_phase[PH_IO_BIT];
        end else begin
            use_alt2 = wide_res;
        end
    end

endmodule

// File: rtl/pmj_residual.sv
module pmj_residual #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24,
    parameter int unsigned FW = 6
) (
    input  logic          inbound,
    input  logic [FW-1:0] fifo_bytes,
    input  logic [CW-1:0] prog_count,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] moved,
    output logic [CW-1:0] rem_count,
    output logic [AW-1:0] next_addr
);

    logic [CW-1:0] fifo_ext;
    logic [CW-1:0] xferred;

    always_comb begin
        fifo_ext  = CW'(fifo_bytes);
        xferred   = inbound ? (moved + fifo_ext) : (moved - fifo_ext);
        rem_count = prog_count - xferred;
        next_addr = start_addr + AW'(xferred);
    end

endmodule

// File: rtl/pmj_ctrl.sv
module pmj_ctrl
    import pmj_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 24,
    parameter int unsigned FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic [1:0]    alt_we,
    input  logic [AW-1:0] alt_wdata,
    input  logic          bm_active,
    input  logic [2:0]    bm_phase,
    input  logic [2:0]    bus_phase,
    input  logic          wide_res,
    input  logic [FW-1:0] fifo_count,
    input  logic [CW-1:0] bm_count,
    input  logic [AW-1:0] bm_start,
    input  logic [CW-1:0] bm_moved,
    output logic          settle_req,
    output logic          settle_drain,
    input  logic          settle_done,
    input  logic          seq_ack,
    output logic          irq,
    output logic          jump_stb,
    output logic [AW-1:0] jump_addr,
    output logic [CW-1:0] resid_count,
    output logic [AW-1:0] resid_addr,
    output logic          wres_flag
);

    localparam int unsigned NALT = 2;

    pmj_state_e state_q, state_d;

    logic                    ctl_en, ctl_sel;
    logic [NALT-1:0][AW-1:0] alt_addr;
    logic                    sel_alt2_d, sel_alt2_q;
    logic                    inbound_q;
    logic [FW-1:0]           fifo_q;
    logic [CW-1:0]           count_q, moved_q;
    logic [AW-1:0]           start_q;
    logic [CW-1:0]           rem_count_c;
    logic [AW-1:0]           next_addr_c;
    logic                    mismatch;

    pmj_cfg #(.AW(AW), .NALT(NALT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .alt_we    (alt_we),
        .alt_wdata (alt_wdata),
        .ctl_en    (ctl_en),
        .ctl_sel   (ctl_sel),
        .alt_addr  (alt_addr)
    );

    pmj_target u_target (
        .ctl_sel     (ctl_sel),
        .instr_phase (bm_phase),
        .wide_res    (wide_res),
        .use_alt2    (sel_alt2_d)
    );

    pmj_residual #(.AW(AW), .CW(CW), .FW(FW)) u_resid (
        .inbound    (inbound_q),
        .fifo_bytes (fifo_q),
        .prog_count (count_q),
        .start_addr (start_q),
        .moved      (moved_q),
        .rem_count  (rem_count_c),
        .next_addr  (next_addr_c)
    );

    assign mismatch = (state_q == ST_IDLE) && bm_active && (bus_phase != bm_phase);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mismatch) begin
                    if (!ctl_en)               state_d = ST_IRQ;
                    else if (fifo_count != '0) state_d = ST_SETTLE;
                    else                       state_d = ST_COMPUTE;
                end
            end
            ST_SETTLE:  if (settle_done) state_d = ST_COMPUTE;
            ST_COMPUTE: state_d = ST_JUMP;
            ST_JUMP:    state_d = ST_WAITACK;
            ST_WAITACK: if (seq_ack) state_d = ST_IDLE;
            ST_IRQ:     if (seq_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Capture of the transfer context and residual results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_alt2_q  <= 1'b0;
            inbound_q   <= 1'b0;
            fifo_q      <= '0;
            count_q     <= '0;
            moved_q     <= '0;
            start_q     <= '0;
            wres_flag   <= 1'b0;
            resid_count <= '0;
            resid_addr  <= '0;
        end else begin
            if (mismatch) begin
                sel_alt2_q <= sel_alt2_d;
                inbound_q  <= bm_phase[PH_IO_BIT];
                fifo_q     <= fifo_count;
                count_q    <= bm_count;
                moved_q    <= bm_moved;
                start_q    <= bm_start;
                wres_flag  <= ctl_en & wide_res;
            end
            if (state_q == ST_COMPUTE) begin
                resid_count <= rem_count_c;
                resid_addr  <= next_addr_c;
            end
        end
    end

    // Outputs
    always_comb begin
        settle_req   = (state_q == ST_SETTLE);
        settle_drain = settle_req & inbound_q;
        irq          = (state_q == ST_IRQ);
        jump_stb     = (state_q == ST_JUMP);
        jump_addr    = jump_stb ? alt_addr[sel_alt2_q] : '0;
    end

    AST_IRQ_ONLY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(ctl_en)); // R3
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !seq_ack) |=> irq); // R3
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        jump_stb |=> !jump_stb); // R4
    AST_NO_IRQ_WITH_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && jump_stb)); // R4
    AST_SETTLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_req && !settle_done) |=> settle_req); // R5
    AST_TARGET_PROGRAMMED: assert property (@(posedge clk) disable iff (!rst_n)
        jump_stb |-> (jump_addr == alt_addr[0] || jump_addr == alt_addr[1])); // R8
    AST_STB_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_req && settle_done) |=> !jump_stb); // R12

endmodule

// File: tb/pmj_ctrl_tb.sv
module pmj_ctrl_tb_top;

    localparam int AW = 32;
    localparam int CW = 24;
    localparam int FW = 6;
    localparam logic [AW-1:0] ALT1 = 32'hA000_0000;
    localparam logic [AW-1:0] ALT2 = 32'hB000_0040;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic [1:0]    alt_we = '0;
    logic [AW-1:0] alt_wdata = '0;
    logic          bm_active = 1'b0;
    logic [2:0]    bm_phase = '0;
    logic [2:0]    bus_phase = '0;
    logic          wide_res = 1'b0;
    logic [FW-1:0] fifo_count = '0;
    logic [CW-1:0] bm_count = '0;
    logic [AW-1:0] bm_start = '0;
    logic [CW-1:0] bm_moved = '0;
    logic          settle_req, settle_drain;
    logic          settle_done = 1'b0;
    logic          seq_ack = 1'b0;
    logic          irq, jump_stb, wres_flag;
    logic [AW-1:0] jump_addr, resid_addr;
    logic [CW-1:0] resid_count;

    always #2.5 clk = ~clk;

    pmj_ctrl #(.AW(AW), .CW(CW), .FW(FW)) dut_i (.*);

    typedef struct {
        bit            is_irq;
        logic [AW-1:0] addr;
        logic [CW-1:0] rc;
        logic [AW-1:0] ra;
        bit            wres;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   n_evt  = 0;
    int   cyc    = 0;
    logic irq_prev = 1'b0;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected items as events appear
    always @(negedge clk) begin
        if (rst_n) begin
            if ((irq && !irq_prev) || jump_stb) begin
                n_evt++;
                if (q.size() == 0) begin
                    check("R11", "unexpected event", {62'd0, irq, jump_stb}, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.req, "event kind irq", {63'd0, irq}, {63'd0, e.is_irq});
                    check(e.req, "event kind jump", {63'd0, jump_stb}, {63'd0, !e.is_irq});
                    if (!e.is_irq && jump_stb) begin
                        check(e.req, "jump_addr", {32'd0, jump_addr}, {32'd0, e.addr});
                        check(e.req, "resid_count", {40'd0, resid_count}, {40'd0, e.rc});
                        check(e.req, "resid_addr", {32'd0, resid_addr}, {32'd0, e.ra});
                        check("R10", "wres_flag", {63'd0, wres_flag}, {63'd0, e.wres});
                    end
                end
            end
            irq_prev = irq;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 100000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_evt(input int target);
        while (n_evt < target) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk) seq_ack = 1'b1;
        @(negedge clk) seq_ack = 1'b0;
    endtask

    // Driver: presents one mismatch and pushes the expected result
    task automatic run_case(input string req, input bit en, input bit sel, input logic [2:0] ph,
                            input logic [2:0] bph, input bit wr, input int fifo, input int cnt,
                            input logic [AW-1:0] st, input int mv, input bit exp_alt2, input bit do_ack);
        exp_t e;
        int   xfer;
        int   tgt;
        xfer = ph[0] ? (mv + fifo) : (mv - fifo);
        e.is_irq = !en;
        e.addr   = exp_alt2 ? ALT2 : ALT1;
        e.rc     = CW'(cnt - xfer);
        e.ra     = st + AW'(xfer);
        e.wres   = en & wr;
        e.req    = req;
        q.push_back(e);
        tgt = n_evt + 1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {en, sel, 6'b0};
        @(negedge clk);
        cfg_we = 1'b0;
        bm_active = 1'b1; bm_phase = ph; bus_phase = bph; wide_res = wr;
        fifo_count = FW'(fifo); bm_count = CW'(cnt); bm_start = st; bm_moved = CW'(mv);
        @(negedge clk);
        bm_active = 1'b0;
        if (!en) begin
            check("R3", "irq next cycle", {63'd0, irq}, 64'd1);
            check("R3", "no settle", {63'd0, settle_req}, 64'd0);
            repeat (3) @(negedge clk);
            check("R3", "irq held", {63'd0, irq}, 64'd1);
            ack();
            check("R3", "irq cleared by ack", {63'd0, irq}, 64'd0);
        end else if (fifo != 0) begin
            check(ph[0] ? "R6" : "R5", "settle_req", {63'd0, settle_req}, 64'd1);
            check(ph[0] ? "R6" : "R5", "settle_drain", {63'd0, settle_drain}, {63'd0, ph[0]});
            check("R4", "no irq", {63'd0, irq}, 64'd0);
            settle_done = 1'b1;
            @(negedge clk) settle_done = 1'b0;
            check("R12", "strobe not yet", {63'd0, jump_stb}, 64'd0);
            @(negedge clk);
            check("R12", "strobe on second cycle", {63'd0, jump_stb}, 64'd1);
            wait_evt(tgt);
            @(negedge clk);
            check("R4", "strobe one cycle", {63'd0, jump_stb}, 64'd0);
            if (do_ack) ack();
        end else begin
            check("R7", "no settle on empty fifo", {63'd0, settle_req}, 64'd0);
            check("R7", "strobe not yet", {63'd0, jump_stb}, 64'd0);
            @(negedge clk);
            check("R7", "strobe second cycle", {63'd0, jump_stb}, 64'd1);
            wait_evt(tgt);
            @(negedge clk);
            if (do_ack) ack();
        end
        wait_evt(tgt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "ctl reset", {56'd0, cfg_rdata}, 64'h00);
        check("R1", "irq reset", {63'd0, irq}, 64'd0);
        check("R1", "stb reset", {63'd0, jump_stb}, 64'd0);
        check("R1", "settle reset", {63'd0, settle_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ctl after release", {56'd0, cfg_rdata}, 64'h00);

        cfg_we = 1'b1; cfg_wdata = 8'hFF;
        @(negedge clk) cfg_we = 1'b0;
        check("R2", "ctl write FF", {56'd0, cfg_rdata}, 64'hF2);
        cfg_we = 1'b1; cfg_wdata = 8'h0D;
        @(negedge clk) cfg_we = 1'b0;
        check("R2", "ctl write 0D", {56'd0, cfg_rdata}, 64'h00);

        alt_we = 2'b01; alt_wdata = ALT1;
        @(negedge clk) begin alt_we = 2'b10; alt_wdata = ALT2; end
        @(negedge clk) alt_we = 2'b00;

        // R3: interrupt mode, data out vs status
        run_case("R3", 1'b0, 1'b0, 3'b000, 3'b011, 1'b0, 4, 50, 32'h500, 10, 1'b0, 1'b1);
        // R5 / R8: send, selector 0, no wide residue -> alt1
        run_case("R5", 1'b1, 1'b0, 3'b000, 3'b001, 1'b0, 5, 100, 32'h1000, 20, 1'b0, 1'b1);
        // R6 / R8 / R10: receive, selector 0, wide residue -> alt2
        run_case("R6", 1'b1, 1'b0, 3'b001, 3'b011, 1'b1, 3, 64, 32'h2000, 10, 1'b1, 1'b1);
        // R7 / R9: message in, bus message out, empty fifo -> alt2 by instruction
        run_case("R9", 1'b1, 1'b1, 3'b111, 3'b110, 1'b0, 0, 40, 32'h3000, 40, 1'b1, 1'b1);
        // R9: command with bus status and wide residue -> alt1; ack withheld
        run_case("R9", 1'b1, 1'b1, 3'b010, 3'b011, 1'b1, 2, 30, 32'h40, 12, 1'b0, 1'b0);

        // R11: mismatch while awaiting ack is ignored
        @(negedge clk);
        bm_active = 1'b1; bm_phase = 3'b000; bus_phase = 3'b111; fifo_count = '0;
        repeat (3) @(negedge clk);
        bm_active = 1'b0;
        check("R11", "no settle while busy", {63'd0, settle_req}, 64'd0);
        ack();
        repeat (6) @(negedge clk);
        check("R11", "no event after busy mismatch", n_evt, 64'd5);

        // R11: phase difference with bm_active low
        bm_active = 1'b0; bm_phase = 3'b001; bus_phase = 3'b010;
        repeat (6) @(negedge clk);
        check("R11", "idle mismatch no irq", {63'd0, irq}, 64'd0);
        check("R11", "idle mismatch no stb", n_evt, 64'd5);
        check("R11", "queue drained", q.size(), 64'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule